// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with Result Registers

This block is a 32-bit integer multiply and divide engine. Its results go to two dedicated result registers: HI and LO. A command is offered on `cmdValid` together with an operation code and two operands. Multiplies take a short fixed number of cycles. Divides use a restoring shift-subtract loop that retires one quotient bit per clock, followed by one cycle that corrects the signs. Software may also load HI or LO directly from `opA`.

A read port returns HI or LO combinationally. While an operation is in flight, `busy` is high, and a read request raises `stall` until the registers hold the new result. Two cases have fixed, defined results instead of a fault: division by zero, and the signed divide of the most negative value by minus one.

Operation codes on `cmdOp`:

| Code | Operation |
|------|-----------|
| 0 | signed multiply |
| 1 | unsigned multiply |
| 2 | signed divide |
| 3 | unsigned divide |
| 4 | write HI |
| 5 | write LO |
| 6, 7 | ignored |

Top module: `mdu_hilo`

## Requirements
- R1: Multiply forms the full 64-bit product of `opA` and `opB`, with code 0 treating both operands as signed and code 1 as unsigned. The product's bits 63..32 go to HI and bits 31..0 go to LO.
- R2: Signed divide (code 2) with a nonzero divisor puts the quotient, truncated toward zero, in LO. It puts the remainder in HI, and the remainder carries the dividend's sign.
- R3: Unsigned divide (code 3) with a nonzero divisor puts the quotient in LO and the remainder in HI.
- R4: Signed divide by zero sets HI to the dividend. LO becomes 0x00000001 when the dividend is negative and 0xFFFFFFFF otherwise.
- R5: Unsigned divide by zero sets LO to 0xFFFFFFFF and HI to the dividend.
- R6: Signed divide of 0x80000000 by 0xFFFFFFFF yields LO = 0x80000000 and HI = 0.
- R7: Code 4 loads HI from `opA` and code 5 loads LO from `opA`. Each takes effect at the accepting edge and leaves the other register unchanged.
- R8: After the accepting edge, `busy` stays high for exactly 2 cycles on a multiply and 33 cycles on a divide (32 iteration cycles plus one correction cycle). It stays low for codes 4 and 5.
- R9: A command offered while `busy` is high has no effect, and codes 6 and 7 have no effect at any time.
- R10: `readData` shows HI when `readSel` is 1 and LO when it is 0. `stall` is high exactly when `readReq` is high while `busy` is high.
- R11: A synchronous active-high `rst` clears HI, LO and `busy`, including in the middle of a divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command offered this cycle |
| cmdOp | input | 3 | Operation code (see table above) |
| opA | input | 32 | Multiplicand, dividend, or value to load |
| opB | input | 32 | Multiplier or divisor |
| readReq | input | 1 | Read of a result register requested |
| readSel | input | 1 | 1 selects HI, 0 selects LO |
| readData | output | 32 | Selected result register |
| stall | output | 1 | Read must wait; the result is not yet valid |
| busy | output | 1 | Multiply or divide in flight |

## Verification
The hardest case to reach from the ports is a command that collides with an operation in flight. That means a register write or a new divide arriving during the 33-cycle divide window, and a reset landing in the middle of the iteration loop. The bench holds `cmdValid` high across the accepting edge into the busy window and changes the command while it stays high. It probes `stall` with `readReq` on and off inside the window, and asserts reset a few cycles after a divide starts from nonzero HI/LO. The sign and special-value corners are exercised by directed operands, and seeded random operands are mixed in with divisors shortened by random shifts so that quotients stay nontrivial.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MUL_S  = 3'd0,
    OP_MUL_U  = 3'd1,
    OP_DIV_S  = 3'd2,
    OP_DIV_U  = 3'd3,
    OP_SET_HI = 3'd4,
    OP_SET_LO = 3'd5
  } mduOp_e;

  // strobes from control to datapath, at most one action per cycle
  typedef struct packed {
    logic signedOp;
    logic loadMul;
    logic loadDiv;
    logic divStep;
    logic commitMul;
    logic commitDiv;
    logic writeHi;
    logic writeLo;
  } mduStrobe_t;

endpackage

// File: rtl/mdu_div_step.sv
module mdu_div_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] remIn,
  input  logic [WIDTH-1:0] quoIn,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] remOut,
  output logic [WIDTH-1:0] quoOut
);

  logic [WIDTH:0]   shifted;
  logic [WIDTH+1:0] diff;
  logic             fits;

  always_comb begin
    shifted = {remIn, quoIn[WIDTH-1]};
    diff    = {1'b0, shifted} - {2'b00, divisor};
    fits    = ~diff[WIDTH+1];
    remOut  = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
    quoOut  = {quoIn[WIDTH-2:0], fits};
  end

endmodule

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int MUL_CYCLES = 2,
  parameter int DIV_CYCLES = 32,
  parameter int CNT_W      = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  output logic       busy,
  output mduStrobe_t strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_DIV, ST_FIX} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign busy   = (state != ST_IDLE);
  assign accept = cmdValid && (state == ST_IDLE);

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          case (mduOp_e'(cmdOp))
            OP_MUL_S:  begin strb.loadMul = 1'b1; strb.signedOp = 1'b1; end
            OP_MUL_U:  strb.loadMul = 1'b1;
            OP_DIV_S:  begin strb.loadDiv = 1'b1; strb.signedOp = 1'b1; end
            OP_DIV_U:  strb.loadDiv = 1'b1;
            OP_SET_HI: strb.writeHi = 1'b1;
            OP_SET_LO: strb.writeLo = 1'b1;
            default:   ;
          endcase
        end
      end
      ST_MUL:  strb.commitMul = (cnt == '0);
      ST_DIV:  strb.divStep   = 1'b1;
      ST_FIX:  strb.commitDiv = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strb.loadMul) begin
            state <= ST_MUL;
            cnt   <= CNT_W'(MUL_CYCLES - 1);
          end else if (strb.loadDiv) begin
            state <= ST_DIV;
            cnt   <= CNT_W'(DIV_CYCLES - 1);
          end
        end
        ST_MUL: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_DIV: begin
          if (cnt == '0) state <= ST_FIX;
          else           cnt   <= cnt - 1'b1;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // a command seen while busy must not produce any loading strobe
  assert_no_issue_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(strb.loadMul || strb.loadDiv || strb.writeHi || strb.writeLo));

  // at most one register-changing action per cycle
  assert_single_action_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadMul, strb.loadDiv, strb.commitMul, strb.commitDiv,
              strb.writeHi, strb.writeLo}));

  // the correction cycle only ever follows the iteration loop
  assert_fix_after_loop_R8: assert property (@(posedge clk) disable iff (rst)
    strb.commitDiv |-> $past(strb.divStep));

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int WIDTH          = 32,
  parameter int STEPS_PER_CYCLE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  mduStrobe_t       strb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  localparam int PW = 2 * WIDTH + 2;

  logic [WIDTH-1:0] hiReg, loReg;
  logic [WIDTH-1:0] aReg, bReg;
  logic             signedReg;
  logic [WIDTH-1:0] remReg, quoReg, divMag;

  function automatic logic [WIDTH-1:0] magOf(input logic [WIDTH-1:0] x,
                                             input logic sgn);
    return (sgn && x[WIDTH-1]) ? (~x + 1'b1) : x;
  endfunction

  // product over sign- or zero-extended operands
  logic [WIDTH:0]   extA, extB;
  logic [PW-1:0]    wideA, wideB, prodWide;
  logic [2*WIDTH-1:0] product;

  always_comb begin
    extA     = {signedReg & aReg[WIDTH-1], aReg};
    extB     = {signedReg & bReg[WIDTH-1], bReg};
    wideA    = {{(PW-WIDTH-1){extA[WIDTH]}}, extA};
    wideB    = {{(PW-WIDTH-1){extB[WIDTH]}}, extB};
    prodWide = wideA * wideB;
    product  = prodWide[2*WIDTH-1:0];
  end

  // iteration chain, unrolled when several bits retire per cycle
  logic [WIDTH-1:0] remChain [0:STEPS_PER_CYCLE];
  logic [WIDTH-1:0] quoChain [0:STEPS_PER_CYCLE];

  assign remChain[0] = remReg;
  assign quoChain[0] = quoReg;

  for (genvar s = 0; s < STEPS_PER_CYCLE; s++) begin : g_step
    mdu_div_step #(.WIDTH(WIDTH)) u_step (
      .remIn  (remChain[s]),
      .quoIn  (quoChain[s]),
      .divisor(divMag),
      .remOut (remChain[s+1]),
      .quoOut (quoChain[s+1])
    );
  end

  // sign correction and defined results for the special cases
  logic             negQ, negR, divZero;
  logic [WIDTH-1:0] quoFinal, remFinal;

  always_comb begin
    negQ    = signedReg & (aReg[WIDTH-1] ^ bReg[WIDTH-1]);
    negR    = signedReg & aReg[WIDTH-1];
    divZero = (bReg == '0);
    if (divZero) begin
      remFinal = aReg;
      quoFinal = (signedReg && aReg[WIDTH-1]) ? WIDTH'(1) : '1;
    end else begin
      quoFinal = negQ ? (~quoReg + 1'b1) : quoReg;
      remFinal = negR ? (~remReg + 1'b1) : remReg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiReg     <= '0;
      loReg     <= '0;
      aReg      <= '0;
      bReg      <= '0;
      signedReg <= 1'b0;
      remReg    <= '0;
      quoReg    <= '0;
      divMag    <= '0;
    end else begin
      if (strb.loadMul || strb.loadDiv) begin
        aReg      <= opA;
        bReg      <= opB;
        signedReg <= strb.signedOp;
      end
      if (strb.loadDiv) begin
        remReg <= '0;
        quoReg <= magOf(opA, strb.signedOp);
        divMag <= magOf(opB, strb.signedOp);
      end
      if (strb.divStep) begin
        remReg <= remChain[STEPS_PER_CYCLE];
        quoReg <= quoChain[STEPS_PER_CYCLE];
      end
      if (strb.commitMul) begin
        hiReg <= product[2*WIDTH-1:WIDTH];
        loReg <= product[WIDTH-1:0];
      end
      if (strb.commitDiv) begin
        hiReg <= remFinal;
        loReg <= quoFinal;
      end
      if (strb.writeHi) hiReg <= opA;
      if (strb.writeLo) loReg <= opA;
    end
  end

  assign hiOut = hiReg;
  assign loOut = loReg;

  assert_sethi_keeps_lo_R7: assert property (@(posedge clk) disable iff (rst)
    strb.writeHi |=> (hiReg == $past(opA)) && $stable(loReg));

  assert_setlo_keeps_hi_R7: assert property (@(posedge clk) disable iff (rst)
    strb.writeLo |=> (loReg == $past(opA)) && $stable(hiReg));

  assert_udiv_zero_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (strb.commitDiv && bReg == '0 && !signedReg) |=> (loReg == '1));

  assert_reset_clears_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hiReg == '0 && loReg == '0));

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
  parameter int WIDTH           = 32,
  parameter int MUL_CYCLES      = 2,
  parameter int STEPS_PER_CYCLE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             readReq,
  input  logic             readSel,
  output logic [WIDTH-1:0] readData,
  output logic             stall,
  output logic             busy
);

  import mdu_pkg::*;

  localparam int DIV_CYCLES = WIDTH / STEPS_PER_CYCLE;
  localparam int CNT_W      = $clog2(DIV_CYCLES + MUL_CYCLES + 1);

  mduStrobe_t       strb;
  logic [WIDTH-1:0] hiVal, loVal;

  mdu_ctrl #(
    .MUL_CYCLES(MUL_CYCLES),
    .DIV_CYCLES(DIV_CYCLES),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .busy    (busy),
    .strb    (strb)
  );

  mdu_datapath #(
    .WIDTH          (WIDTH),
    .STEPS_PER_CYCLE(STEPS_PER_CYCLE)
  ) u_dp (
    .clk  (clk),
    .rst  (rst),
    .strb (strb),
    .opA  (opA),
    .opB  (opB),
    .hiOut(hiVal),
    .loOut(loVal)
  );

  assign readData = readSel ? hiVal : loVal;
  assign stall    = readReq & busy;

  // result registers never change while a read would be stalled, except at the commit
  assert_stalled_read_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (stall && !strb.commitMul && !strb.commitDiv) |=> $stable(hiVal) && $stable(loVal));

endmodule

// File: tb/mdu_hilo_bench.sv
module mdu_hilo_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmdValid;
  logic [2:0]  cmdOp;
  logic [31:0] opA, opB;
  logic        readReq, readSel;
  logic [31:0] readData;
  logic        stall, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  mdu_hilo u_mdu_hilo (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .opA(opA), .opB(opB), .readReq(readReq), .readSel(readSel),
    .readData(readData), .stall(stall), .busy(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL R8 watchdog: busy never cleared, actual cycles %0d expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] refMul(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb;
    if (sgn) begin
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      return sa * sb;
    end
    return {32'd0, a} * {32'd0, b};
  endfunction

  // returns {HI, LO}
  function automatic logic [63:0] refDiv(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    int sa, sb;
    if (b == 0) return {a, (sgn && a[31]) ? 32'd1 : 32'hFFFF_FFFF};
    if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'd0, 32'h8000_0000};
    if (sgn) begin
      sa = a; sb = b;
      return {32'(sa % sb), 32'(sa / sb)};
    end
    return {a % b, a / b};
  endfunction

  task automatic readHiLo(output logic [63:0] hl);
    readSel = 1'b1; #1; hl[63:32] = readData;
    readSel = 1'b0; #1; hl[31:0]  = readData;
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       output int busyCycles);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; opA = a; opB = b;
    @(negedge clk);
    cmdValid = 1'b0;
    busyCycles = 0;
    while (busy && busyCycles < 100) begin
      busyCycles++;
      @(negedge clk);
    end
  endtask

  task automatic runOp(input string tag, input logic [2:0] op,
                       input logic [31:0] a, input logic [31:0] b);
    int bc;
    logic [63:0] hl, exp;
    issue(op, a, b, bc);
    readHiLo(hl);
    exp = (op < 2) ? refMul(op == 0, a, b) : refDiv(op == 2, a, b);
    check(tag, hl, exp);
  endtask

  initial begin
    int bc;
    logic [63:0] hl;
    void'($urandom(32'd4242));
    rst = 1'b1; cmdValid = 0; cmdOp = 0; opA = 0; opB = 0; readReq = 0; readSel = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    readHiLo(hl);
    check("R11 reset HI/LO", hl, 64'd0);
    check("R11 reset busy", {63'd0, busy}, 64'd0);

    // R7 direct writes
    issue(3'd4, 32'h1234_5678, 32'd0, bc);
    readHiLo(hl);
    check("R7 set HI", hl, {32'h1234_5678, 32'd0});
    check("R8 no busy on set", bc, 0);
    issue(3'd5, 32'hCAFE_0001, 32'd0, bc);
    readHiLo(hl);
    check("R7 set LO keeps HI", hl, {32'h1234_5678, 32'hCAFE_0001});

    // R9 reserved codes ignored
    issue(3'd6, 32'hFFFF_FFFF, 32'd3, bc);
    readHiLo(hl);
    check("R9 code 6 ignored", {hl, 32'(bc)} >> 32, {32'h1234_5678, 32'hCAFE_0001});
    issue(3'd7, 32'h0, 32'd3, bc);
    readHiLo(hl);
    check("R9 code 7 ignored", hl, {32'h1234_5678, 32'hCAFE_0001});

    // R1 multiply corners and latency (R8)
    issue(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, bc);
    check("R8 multiply busy cycles", bc, 2);
    readHiLo(hl);
    check("R1 signed -1*-1", hl, 64'd1);
    runOp("R1 unsigned max*max", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runOp("R1 signed min*-1", 3'd0, 32'h8000_0000, 32'hFFFF_FFFF);
    runOp("R1 signed neg*pos", 3'd0, 32'hFFFF_FFF9, 32'd3);

    // R2 signed divide signs
    issue(3'd2, 32'hFFFF_FFF9, 32'd2, bc);
    check("R8 divide busy cycles", bc, 33);
    readHiLo(hl);
    check("R2 -7/2", hl, {32'hFFFF_FFFF, 32'hFFFF_FFFD});
    runOp("R2 7/-2", 3'd2, 32'd7, 32'hFFFF_FFFE);
    runOp("R2 -7/-2", 3'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
    runOp("R3 unsigned big", 3'd3, 32'hFFFF_FFF9, 32'd2);
    runOp("R3 unsigned small dividend", 3'd3, 32'd5, 32'd9);

    // R4 / R5 / R6 special cases
    issue(3'd2, 32'hFFFF_FF00, 32'd0, bc);
    readHiLo(hl);
    check("R4 neg/0", hl, {32'hFFFF_FF00, 32'd1});
    runOp("R4 pos/0", 3'd2, 32'd77, 32'd0);
    runOp("R4 zero/0", 3'd2, 32'd0, 32'd0);
    issue(3'd3, 32'h8000_0005, 32'd0, bc);
    readHiLo(hl);
    check("R5 udiv/0", hl, {32'h8000_0005, 32'hFFFF_FFFF});
    issue(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, bc);
    readHiLo(hl);
    check("R6 min/-1", hl, {32'd0, 32'h8000_0000});

    // R9 / R10 command during busy, stall behaviour
    @(negedge clk);
    cmdValid = 1; cmdOp = 3'd2; opA = 32'd100; opB = 32'd7;
    @(negedge clk);
    cmdOp = 3'd4; opA = 32'hDEAD_BEEF;
    readReq = 1'b1; #1;
    check("R10 stall while busy", {63'd0, stall}, 64'd1);
    @(negedge clk);
    cmdOp = 3'd1; opA = 32'd3; opB = 32'd3;
    readReq = 1'b0; #1;
    check("R10 no stall without request", {63'd0, stall}, 64'd0);
    @(negedge clk);
    cmdValid = 0;
    while (busy) @(negedge clk);
    readHiLo(hl);
    check("R9 commands ignored while busy", hl, {32'd2, 32'd14});
    readReq = 1'b1; #1;
    check("R10 no stall when idle", {63'd0, stall}, 64'd0);
    readReq = 1'b0;

    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [2:0]  op;
      logic [31:0] a, b;
      op = 3'($urandom % 4);
      a  = $urandom;
      b  = $urandom;
      case ($urandom % 8)
        0: b = 32'd0;
        1, 2, 3: b = b >> ($urandom % 32);
        4: b = 32'hFFFF_FFFF;
        default: ;
      endcase
      case (op)
        3'd0: runOp("R1 random signed mul", op, a, b);
        3'd1: runOp("R1 random unsigned mul", op, a, b);
        3'd2: runOp("R2 random signed div", op, a, b);
        default: runOp("R3 random unsigned div", op, a, b);
      endcase
    end

    // R11 reset in the middle of a divide
    issue(3'd4, 32'h5555_5555, 32'd0, bc);
    @(negedge clk);
    cmdValid = 1; cmdOp = 3'd3; opA = 32'd1000; opB = 32'd3;
    @(negedge clk);
    cmdValid = 0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; #1;
    check("R11 busy cleared mid-divide", {63'd0, busy}, 64'd0);
    readHiLo(hl);
    check("R11 HI/LO cleared mid-divide", hl, 64'd0);
    repeat (40) @(negedge clk);
    readHiLo(hl);
    check("R11 aborted divide never commits", hl, 64'd0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule